// File: doc/BRIEF.md
# Word/Byte ALU with Status Flags

This block is the arithmetic and logic stage of a 16-bit microcontroller datapath. Each cycle it takes a source operand, a destination operand, an operation code, a byte/word select and an incoming carry. It produces a result combinationally, together with a write-enable that says whether the result should be stored. A four-bit status register (carry, zero, negative, overflow) loads the flags of the operation on the next rising clock edge. Operations that are defined to leave the flags alone hold that register.

The operations cover binary add and subtract, each with and without the incoming carry, and decimal (BCD) add with carry across all digits. They also cover AND, XOR, bit clear and bit set. Bit test and compare update the flags only. Sign extension of a byte and byte swap complete the set. Subtraction uses carry as the inverse of borrow, so the carry chains through multi-word add, subtract and decimal-add sequences. Instruction decode, operand fetch and the register file sit outside the block.

Top module: `wbalu`

## Requirements
- R1: The operation code is 4 bits. Code 0 (add) returns dst+src. Code 1 (add with carry) returns dst+src+cin_i. Carry is the carry out of the operation width. Overflow is set when both operands have the same sign and the result's sign differs from it. N is set from the result's sign bit and Z when the result is zero.
- R2: Code 2 (subtract) returns dst−src, computed as dst+~src+1. Code 3 (subtract with carry) returns dst+~src+cin_i. Carry is 1 when no borrow occurs and 0 when a borrow occurs. Overflow is set when the operands differ in sign and the result's sign differs from dst's. N and Z follow the result.
- R3: Code 4 (decimal add) treats each nibble as a BCD digit and returns dst+src+cin_i in BCD, with a carry chain between digits. Carry is the decimal carry out of the top digit of the operation width. V is 0, and N and Z follow the result.
- R4: Code 5 (AND) returns dst&src, and code 6 (XOR) returns dst^src. For both, N and Z follow the result and C is the inverse of Z. V is 0 for AND. For XOR, V is set when both operands are negative.
- R5: Code 7 (bit clear) returns dst&~src and code 8 (bit set) returns dst|src. Both leave all four flags unchanged.
- R6: Code 9 (bit test) computes dst&src and drives wr_en_o low. It clears V, sets N from the result's sign bit, sets Z when the result is zero and sets C when the result is nonzero.
- R7: Code 10 (compare) drives wr_en_o low and sets the flags exactly as subtract (code 2) would for the same operands.
- R8: Code 11 (sign extend) always works on the whole word and copies src bit 7 into bits 15:8. N and Z follow the result, C is the inverse of Z and V is 0.
- R9: Code 12 (byte swap) always works on the whole word, exchanges the two bytes of src and leaves all flags unchanged.
- R10: When byte_i is 1, operations other than codes 11 and 12 use bits 7:0 of the operands only. Result bits 15:8 are then zero, and N, C and V come from bit 7 and the byte-wide carry.
- R11: flags_o bit order is [3]=V, [2]=N, [1]=Z, [0]=C. It loads the new flags on the rising clock edge after the operation is presented and resets to 0000 while rst_n is low.
- R12: Codes 13 to 15 drive res_o to zero and wr_en_o low, and leave the flags unchanged.
- R13: For codes 0 to 8 and 11 to 12, wr_en_o is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; status flags load on the rising edge |
| rst_n | input | 1 | Active-low reset of the status flags |
| src_i | input | 16 | Source operand |
| dst_i | input | 16 | Destination operand |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte-wide operation |
| cin_i | input | 1 | Incoming carry flag |
| res_o | output | 16 | Result |
| wr_en_o | output | 1 | Result should be written back |
| flags_o | output | 4 | Registered status flags {V,N,Z,C} |

## Verification
The hardest case to reach is a decimal carry that ripples through every digit at once, for example 9999 plus 0 with a carry in. Random operands almost never produce it. The bench therefore builds decimal operands digit by digit, so that nines and carries show up often, and adds directed word and byte cases at the ripple edge. Flag-holding operations are always issued right after an operation that left a known non-zero flag pattern, so that holding the register can be told apart from reloading it with the same value.

// File: rtl/wbalu_pkg.sv
package wbalu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBC = 4'd3,
    OP_DADD = 4'd4,
    OP_AND  = 4'd5,
    OP_XOR  = 4'd6,
    OP_BIC  = 4'd7,
    OP_BIS  = 4'd8,
    OP_BIT  = 4'd9,
    OP_CMP  = 4'd10,
    OP_SXT  = 4'd11,
    OP_SWPB = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  // One BCD digit step: returns {carry_out, digit}
  function automatic logic [4:0] bcd_digit(input logic [3:0] a, input logic [3:0] b,
                                           input logic ci);
    logic [4:0] raw;
    logic [4:0] adj;
    raw = {1'b0, a} + {1'b0, b} + {4'b0, ci};
    adj = raw + 5'd6;
    if (raw > 5'd9) bcd_digit = {1'b1, adj[3:0]};
    else            bcd_digit = {1'b0, raw[3:0]};
  endfunction

  function automatic logic is_arith(input logic [3:0] op);
    is_arith = (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) ||
               (op == OP_SUBC) || (op == OP_CMP);
  endfunction

endpackage

// File: rtl/wbalu_adder.sv
module wbalu_adder #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  input  logic          byte_i,
  output logic [DW-1:0] sum_o,
  output logic          co_o,
  output logic          ov_o
);
  localparam int HW = DW / 2;

  logic [DW:0] wide_w;
  logic [HW:0] half_w;

  always_comb begin
    wide_w = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, ci_i};
    half_w = {1'b0, a_i[HW-1:0]} + {1'b0, b_i[HW-1:0]} + {{HW{1'b0}}, ci_i};
    if (byte_i) begin
      sum_o = {{(DW-HW){1'b0}}, half_w[HW-1:0]};
      co_o  = half_w[HW];
      ov_o  = (a_i[HW-1] == b_i[HW-1]) && (half_w[HW-1] != a_i[HW-1]);
    end else begin
      sum_o = wide_w[DW-1:0];
      co_o  = wide_w[DW];
      ov_o  = (a_i[DW-1] == b_i[DW-1]) && (wide_w[DW-1] != a_i[DW-1]);
    end
  end
endmodule

// File: rtl/wbalu_bcd.sv
module wbalu_bcd #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          ci_i,
  input  logic          byte_i,
  output logic [DW-1:0] sum_o,
  output logic          co_o
);
  import wbalu_pkg::*;
  localparam int NIB  = DW / 4;
  localparam int HNIB = NIB / 2;
  localparam int HW   = DW / 2;

  logic [NIB:0]    chain_w;
  logic [DW-1:0]   digits_w;

  assign chain_w[0] = ci_i;

  for (genvar g = 0; g < NIB; g++) begin : g_digit
    logic [4:0] step_w;
    assign step_w              = bcd_digit(a_i[4*g +: 4], b_i[4*g +: 4], chain_w[g]);
    assign digits_w[4*g +: 4]  = step_w[3:0];
    assign chain_w[g+1]        = step_w[4];
  end

  always_comb begin
    if (byte_i) begin
      sum_o = {{(DW-HW){1'b0}}, digits_w[HW-1:0]};
      co_o  = chain_w[HNIB];
    end else begin
      sum_o = digits_w;
      co_o  = chain_w[NIB];
    end
  end
endmodule

// File: rtl/wbalu_logic.sv
module wbalu_logic #(
  parameter int DW = 16
) (
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] src_i,
  input  logic [DW-1:0] dst_i,
  input  logic          byte_i,
  output logic [DW-1:0] res_o
);
  import wbalu_pkg::*;
  localparam int HW = DW / 2;

  logic [DW-1:0] raw_w;
  logic          whole_w;

  always_comb begin
    whole_w = 1'b0;
    case (op_i)
      OP_AND, OP_BIT: raw_w = dst_i & src_i;
      OP_XOR:         raw_w = dst_i ^ src_i;
      OP_BIC:         raw_w = dst_i & ~src_i;
      OP_BIS:         raw_w = dst_i | src_i;
      OP_SXT: begin
        raw_w   = {{(DW-HW){src_i[HW-1]}}, src_i[HW-1:0]};
        whole_w = 1'b1;
      end
      OP_SWPB: begin
        raw_w   = {src_i[HW-1:0], src_i[DW-1:HW]};
        whole_w = 1'b1;
      end
      default:        raw_w = '0;
    endcase
    if (byte_i && !whole_w) res_o = {{(DW-HW){1'b0}}, raw_w[HW-1:0]};
    else                    res_o = raw_w;
  end
endmodule

// File: rtl/wbalu_flagreg.sv
module wbalu_flagreg (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_i,
  input  wbalu_pkg::flags_t    nxt_i,
  output wbalu_pkg::flags_t    q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (upd_i) q_o <= nxt_i;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(q_o)); // R5
endmodule

// File: rtl/wbalu.sv
module wbalu #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   src_i,
  input  logic [15:0]   dst_i,
  input  logic [3:0]    op_i,
  input  logic          byte_i,
  input  logic          cin_i,
  output logic [15:0]   res_o,
  output logic          wr_en_o,
  output logic [3:0]    flags_o
);
  import wbalu_pkg::*;
  localparam int HW = DW / 2;

  // operand preparation
  logic [DW-1:0] src_m_w, dst_m_w, add_b_w;
  logic          add_ci_w, is_sub_w;

  assign src_m_w  = byte_i ? {{(DW-HW){1'b0}}, src_i[HW-1:0]} : src_i;
  assign dst_m_w  = byte_i ? {{(DW-HW){1'b0}}, dst_i[HW-1:0]} : dst_i;
  assign is_sub_w = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
  assign add_b_w  = is_sub_w ? ~src_m_w : src_m_w;

  always_comb begin
    case (op_i)
      OP_ADDC, OP_SUBC: add_ci_w = cin_i;
      OP_SUB, OP_CMP:   add_ci_w = 1'b1;
      default:          add_ci_w = 1'b0;
    endcase
  end

  // datapath units
  logic [DW-1:0] add_sum_w, bcd_sum_w, log_res_w;
  logic          add_co_w, add_ov_w, bcd_co_w;

  wbalu_adder #(.DW(DW)) u_adder (
    .a_i(dst_m_w), .b_i(add_b_w), .ci_i(add_ci_w), .byte_i(byte_i),
    .sum_o(add_sum_w), .co_o(add_co_w), .ov_o(add_ov_w)
  );

  wbalu_bcd #(.DW(DW)) u_bcd (
    .a_i(dst_m_w), .b_i(src_m_w), .ci_i(cin_i), .byte_i(byte_i),
    .sum_o(bcd_sum_w), .co_o(bcd_co_w)
  );

  wbalu_logic #(.DW(DW)) u_logic (
    .op_i(op_i), .src_i(src_i), .dst_i(dst_i), .byte_i(byte_i), .res_o(log_res_w)
  );

  // result selection and flag computation
  logic [DW-1:0] res_w;
  logic          wr_w, upd_w, narrow_w;
  logic          sign_w, zero_w, src_neg_w, dst_neg_w;
  flags_t        nxt_w, cur_w;

  always_comb begin
    wr_w  = 1'b1;
    upd_w = 1'b1;
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: res_w = add_sum_w;
      OP_CMP: begin res_w = add_sum_w; wr_w = 1'b0; end
      OP_DADD: res_w = bcd_sum_w;
      OP_AND, OP_XOR, OP_SXT: res_w = log_res_w;
      OP_BIT: begin res_w = log_res_w; wr_w = 1'b0; end
      OP_BIC, OP_BIS, OP_SWPB: begin res_w = log_res_w; upd_w = 1'b0; end
      default: begin res_w = '0; wr_w = 1'b0; upd_w = 1'b0; end
    endcase
  end

  assign narrow_w  = byte_i && (op_i != OP_SXT) && (op_i != OP_SWPB);
  assign sign_w    = narrow_w ? res_w[HW-1] : res_w[DW-1];
  assign zero_w    = narrow_w ? (res_w[HW-1:0] == '0) : (res_w == '0);
  assign src_neg_w = byte_i ? src_i[HW-1] : src_i[DW-1];
  assign dst_neg_w = byte_i ? dst_i[HW-1] : dst_i[DW-1];

  always_comb begin
    nxt_w.n = sign_w;
    nxt_w.z = zero_w;
    nxt_w.c = ~zero_w;
    nxt_w.v = 1'b0;
    if (is_arith(op_i)) begin
      nxt_w.c = add_co_w;
      nxt_w.v = add_ov_w;
    end else if (op_i == OP_DADD) begin
      nxt_w.c = bcd_co_w;
    end else if (op_i == OP_XOR) begin
      nxt_w.v = src_neg_w & dst_neg_w;
    end
  end

  wbalu_flagreg u_flags (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_w), .nxt_i(nxt_w), .q_o(cur_w)
  );

  assign res_o   = res_w;
  assign wr_en_o = wr_w;
  assign flags_o = cur_w;

  AST_BIT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_BIT) |=> (!flags_o[3] && (flags_o[0] == !flags_o[1]))); // R6
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> !wr_en_o); // R7
  AST_SXT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_SXT) |-> (res_o[15:8] == {8{res_o[7]}})); // R8
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_i && (op_i != OP_SXT) && (op_i != OP_SWPB)) |-> (res_o[15:8] == 8'h00)); // R10
  AST_UNUSED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i > 4'd12) |-> (!wr_en_o && res_o == 16'h0000)); // R12
  AST_DADD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DADD) |=> !flags_o[3]); // R3
endmodule

// File: tb/wbalu_bench.sv
module wbalu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src, dst;
  logic [3:0]  op;
  logic        bmode, cin;
  logic [15:0] res;
  logic        wr;
  logic [3:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  wbalu u_wbalu (
    .clk(clk), .rst_n(rst_n), .src_i(src), .dst_i(dst), .op_i(op),
    .byte_i(bmode), .cin_i(cin), .res_o(res), .wr_en_o(wr), .flags_o(flags)
  );

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic [3:0]  flg;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [3:0]  mflags = 4'b0000;   // bench view of flags {V,N,Z,C}

  function automatic int to_dec(input logic [15:0] x, input int nd);
    int v = 0;
    for (int i = nd - 1; i >= 0; i--) v = v * 10 + int'(x[4*i +: 4]);
    return v;
  endfunction

  function automatic logic [15:0] to_bcd(input int v, input int nd);
    logic [15:0] r = '0;
    for (int i = 0; i < nd; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic expect_op(input logic [3:0] o, input logic [15:0] s, input logic [15:0] d,
                           input logic b, input logic ci, input string tag);
    item_t it;
    int w = b ? 8 : 16;
    int mask = (1 << w) - 1;
    int si = int'(s) & mask;
    int di = int'(d) & mask;
    int t, r;
    logic fv, fn, fz, fc, upd;
    logic sd, ss, sr;
    r = 0; upd = 1; fv = 0; fc = 0;
    it.wr = 1;
    sd = di[w-1]; ss = si[w-1];
    case (o)
      4'd0, 4'd1: begin
        t = di + si + ((o == 4'd1) ? int'(ci) : 0);
        r = t & mask; sr = r[w-1];
        fc = t[w]; fv = (sd == ss) && (sr != sd);
      end
      4'd2, 4'd3, 4'd10: begin
        t = di + ((~si) & mask) + ((o == 4'd3) ? int'(ci) : 1);
        r = t & mask; sr = r[w-1];
        fc = t[w]; fv = (sd != ss) && (sr != sd);
        if (o == 4'd10) it.wr = 0;
      end
      4'd4: begin
        t = to_dec(16'(di), w / 4) + to_dec(16'(si), w / 4) + int'(ci);
        fc = (t >= ((w == 8) ? 100 : 10000));
        r = int'(to_bcd(t, w / 4));
      end
      4'd5, 4'd9: begin r = di & si; if (o == 4'd9) it.wr = 0; end
      4'd6: begin r = di ^ si; fv = sd && ss; end
      4'd7: begin r = di & ~si & mask; upd = 0; end
      4'd8: begin r = di | si; upd = 0; end
      4'd11: begin r = int'(s[7:0]); if (s[7]) r = r + 32'hFF00; w = 16; end
      4'd12: begin r = int'({s[7:0], s[15:8]}); upd = 0; w = 16; end
      default: begin r = 0; it.wr = 0; upd = 0; end
    endcase
    fn = r[w-1];
    fz = ((r & ((1 << w) - 1)) == 0);
    if (o == 4'd5 || o == 4'd6 || o == 4'd9 || o == 4'd11) fc = !fz;
    if (upd) mflags = {fv, fn, fz, fc};
    it.res = 16'(r);
    it.flg = mflags;
    it.tag = tag;
    @(negedge clk);
    op = o; src = s; dst = d; bmode = b; cin = ci;
    sb_q.push_back(it);
  endtask

  // monitor: 1 ns after the edge, combinational outputs still reflect the
  // driven item and flags_o has just loaded its flags
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t e;
        e = sb_q.pop_front();
        n_tests++;
        if (res !== e.res || wr !== e.wr || flags !== e.flg) begin
          n_fail++;
          $display("FAIL %s: res=%h wr=%b flags=%b expected res=%h wr=%b flags=%b",
                   e.tag, res, wr, flags, e.res, e.wr, e.flg);
        end
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt_rand(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  initial begin
    op = 4'd0; src = '0; dst = '0; bmode = 0; cin = 0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (flags !== 4'b0000) begin
      n_fail++;
      $display("FAIL R11 reset: flags=%b expected 0000", flags);
    end
    rst_n = 1'b1;

    expect_op(4'd0, 16'hABCD, 16'hABCD, 0, 0, "R1 add word");
    expect_op(4'd1, 16'h1234, 16'h1234, 0, 1, "R1 addc carry in");
    expect_op(4'd0, 16'h0001, 16'h7FFF, 0, 0, "R1 add overflow");
    expect_op(4'd2, 16'h1234, 16'h1234, 0, 0, "R2 sub equal");
    expect_op(4'd3, 16'h0000, 16'hABCD, 0, 1, "R2 subc no borrow");
    expect_op(4'd3, 16'h0001, 16'h0000, 0, 0, "R2 subc borrow");
    expect_op(4'd2, 16'h0001, 16'h8000, 0, 0, "R2 sub overflow");
    expect_op(4'd4, 16'h5678, 16'h5678, 0, 0, "R3 dadd low word");
    expect_op(4'd4, 16'h1234, 16'h1234, 0, 1, "R3 dadd high word");
    expect_op(4'd4, 16'h0000, 16'h9999, 0, 1, "R3 dadd full ripple");
    expect_op(4'd4, 16'h0001, 16'h0099, 1, 0, "R3 R10 dadd byte ripple");
    expect_op(4'd5, 16'h00FF, 16'h000C, 0, 0, "R4 and");
    expect_op(4'd6, 16'h8001, 16'h8000, 0, 0, "R4 xor both negative");
    expect_op(4'd6, 16'h5555, 16'h5555, 0, 0, "R4 xor zero");
    expect_op(4'd0, 16'h8000, 16'h8000, 0, 0, "R1 set flags before hold");
    expect_op(4'd7, 16'h000C, 16'hFFFF, 0, 0, "R5 bic holds flags");
    expect_op(4'd8, 16'h000C, 16'h0000, 0, 0, "R5 bis holds flags");
    expect_op(4'd9, 16'h0080, 16'h00CC, 0, 0, "R6 bit nonzero");
    expect_op(4'd9, 16'h0100, 16'h00CC, 0, 0, "R6 bit zero");
    expect_op(4'd10, 16'h0014, 16'h0012, 0, 0, "R7 cmp less");
    expect_op(4'd10, 16'h0100, 16'h0100, 0, 0, "R7 cmp equal");
    expect_op(4'd11, 16'h00FC, 16'h0000, 0, 0, "R8 sxt negative");
    expect_op(4'd11, 16'h1270, 16'h0000, 1, 0, "R8 sxt ignores byte");
    expect_op(4'd0, 16'h8000, 16'h8000, 0, 0, "R1 set flags before swap");
    expect_op(4'd12, 16'h1234, 16'h0000, 0, 0, "R9 swap");
    expect_op(4'd0, 16'h0001, 16'h12FF, 1, 0, "R10 byte add carry");
    expect_op(4'd2, 16'h3401, 16'h5680, 1, 0, "R10 byte sub overflow");
    expect_op(4'd8, 16'hFF00, 16'h00F0, 1, 0, "R10 byte bis upper zero");
    expect_op(4'd0, 16'hFFFF, 16'h0001, 0, 0, "R1 set flags before unused");
    expect_op(4'd13, 16'hFFFF, 16'hFFFF, 0, 1, "R12 unused 13");
    expect_op(4'd15, 16'h1234, 16'h4321, 1, 0, "R12 unused 15");
    expect_op(4'd5, 16'h0F0F, 16'h00FF, 0, 0, "R13 and writes");

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a, b;
      logic [3:0]  o;
      lfsr = nxt_rand(lfsr); a = lfsr;
      lfsr = nxt_rand(lfsr); b = lfsr;
      lfsr = nxt_rand(lfsr);
      o = 4'(lfsr[3:0] % 16);
      if (o == 4'd4) begin
        for (int k = 0; k < 4; k++) begin
          a[4*k +: 4] = 4'(a[4*k +: 4] % 10);
          b[4*k +: 4] = 4'((b[4*k +: 4] % 3 == 0) ? 9 : b[4*k +: 4] % 10);
        end
      end
      expect_op(o, a, b, lfsr[5], lfsr[7], "R13 random mix");
    end

    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule